// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block walks a linked list of 16-byte transfer descriptors held in memory. After a start pulse it reads the descriptor at the head address one 32-bit word at a time, decodes it, checks it, and offers one transfer request on a valid/ready port. The request carries the buffer address, a byte count, the direction, an ordering hint and a 4-bit transfer mode. A separate data mover carries out the transfer and returns a single-cycle acknowledge. Only after that acknowledge does the walker follow the descriptor's next pointer. When the acknowledged descriptor carries the end flag, the walker pulses `done` instead.

Both the descriptor read port and the transfer request port follow valid/ready rules. Once valid is high, the walker holds it, together with every payload field, until the cycle in which ready is high. Back-pressure on either port only stretches the walk; it never changes what is issued. Read responses are accepted in any cycle while a read is outstanding, and only one read is outstanding at a time.

A chain is aborted with a one-cycle `error` pulse and a held `err_code` when any of these occurs: a zero length, a transfer that would run past the top of the 32-bit address space, a change of direction part-way through the chain, or a chain longer than `MAX_DESC` descriptors, which guards against loops.

Top module: `sgw_chain_walker`

## Requirements
- R1: Descriptor word k (k = 0..3) is read from address base + 4k, in increasing k, and is little-endian. Word 0 is the buffer address. Word 1 is the length in 8-byte units. Word 2 bits [7:0] are the flag byte: bit 4 = ordering hint, bit 5 = outbound, bit 7 = last. The other flag bits are ignored. Word 2 bits [11:8] are the mode, and bits [31:12] are ignored. Word 3 is the next-descriptor address.
- R2: Each request carries the descriptor address, `xfer_bytes` = length × 8 (35 bits), and the outbound, ordering and mode fields of that descriptor.
- R3: While `xfer_valid` is high and `xfer_ready` is low, `xfer_valid` and all request fields stay unchanged.
- R4: After a request is accepted, the walker issues no read and no request until `xfer_ack`. After the acknowledge of a non-last descriptor, it fetches from that descriptor's next pointer.
- R5: After the acknowledge of a descriptor whose last flag is set, `done` pulses high for exactly the following cycle. The next pointer of that descriptor is never read.
- R6: A descriptor with length 0 issues no request and aborts the chain with `error` and `err_code` = 0.
- R7: If address + bytes exceeds 2^32, the chain aborts with `err_code` = 1. Ending exactly at 2^32 is allowed.
- R8: If a descriptor's outbound flag differs from that of the chain's first descriptor, the chain aborts with `err_code` = 2.
- R9: After the acknowledge of the MAX_DESC-th descriptor, if that descriptor is not last, the chain aborts with `err_code` = 3 and no further reads occur.
- R10: `busy` is high from the cycle after an accepted start until the cycle in which `done` or `error` is high. A `start` while busy is ignored. `done` and `error` never occur together.
- R11: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_addr` stay unchanged. A `rsp_valid` is taken as the data of the single outstanding read.
- R12: When several checks fail on one descriptor, the code follows the priority zero length (0), then boundary (1), then direction (2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk at `head_addr` (ignored while busy) |
| head_addr | input | 32 | Address of the first descriptor |
| busy | output | 1 | A walk is in progress |
| rd_valid | output | 1 | Descriptor word read request |
| rd_ready | input | 1 | Memory accepts the read request |
| rd_addr | output | 32 | Byte address of the word read |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | DATA_W | Read data word |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Data mover accepts the request |
| xfer_addr | output | 32 | Buffer address |
| xfer_bytes | output | 35 | Transfer length in bytes |
| xfer_outbound | output | 1 | 1 = write to device |
| xfer_order | output | 1 | Ordering hint |
| xfer_mode | output | 4 | Transfer mode |
| xfer_ack | input | 1 | Single-cycle pulse: the accepted transfer has finished |
| done | output | 1 | Single-cycle pulse: chain completed |
| error | output | 1 | Single-cycle pulse: chain aborted |
| err_code | output | 2 | Cause of the last abort |

## Verification
On every cycle the assertions check the stability of both valid/ready ports under back-pressure, the silence on both ports while an acknowledge is pending, and that `done` follows an acknowledge. They also check that no issued request has a zero length or crosses the 4 GiB limit, that the number of requests per walk never exceeds `MAX_DESC`, and that `done` and `error` are exclusive. Only the directed scenarios can show the values of the decoded fields: byte scaling, flag positions, the ignored byte positions, the number of reads when a next pointer must be ignored, and the error code chosen for each fault and its priority.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int SGW_ADDR_W     = 32;
  localparam int SGW_DESC_BITS  = 128;
  localparam int SGW_BYTES_W    = 35;

  // flag byte bit positions (decoded by the data mover's convention)
  localparam int FLG_ORDER = 4;
  localparam int FLG_OUT   = 5;
  localparam int FLG_LAST  = 7;

  typedef enum logic [1:0] {
    ERR_ZERO_LEN = 2'd0,
    ERR_CROSS    = 2'd1,
    ERR_DIR      = 2'd2,
    ERR_LONG     = 2'd3
  } sgw_err_e;

  // word 0 in the low bits, little-endian byte order
  typedef struct packed {
    logic [31:0] next;
    logic [7:0]  rsvd;
    logic [7:0]  pkt_len;
    logic [7:0]  mode_byte;
    logic [7:0]  flags;
    logic [31:0] len_units;
    logic [31:0] buf_addr;
  } sgw_desc_t;
endpackage

// File: rtl/sgw_fetch.sv
module sgw_fetch
  import sgw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [SGW_ADDR_W-1:0] base,
  output logic                  rd_valid,
  input  logic                  rd_ready,
  output logic [SGW_ADDR_W-1:0] rd_addr,
  input  logic                  rsp_valid,
  input  logic [DATA_W-1:0]     rsp_data,
  output logic                  desc_valid,
  output sgw_desc_t             desc
);
  localparam int WORDS  = SGW_DESC_BITS / DATA_W;
  localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int STRIDE = DATA_W / 8;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fetch_st_e;

  fetch_st_e               st_q;
  logic [IDX_W-1:0]        idx_q;
  logic [SGW_ADDR_W-1:0]   base_q;
  logic [SGW_DESC_BITS-1:0] buf_q;

  assign rd_valid = (st_q == F_REQ);
  assign rd_addr  = base_q + SGW_ADDR_W'(int'(idx_q) * STRIDE);
  assign desc     = sgw_desc_t'(buf_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= F_IDLE;
      idx_q      <= '0;
      base_q     <= '0;
      buf_q      <= '0;
      desc_valid <= 1'b0;
    end else begin
      desc_valid <= 1'b0;
      case (st_q)
        F_IDLE: if (go) begin
          base_q <= base;
          idx_q  <= '0;
          st_q   <= F_REQ;
        end
        F_REQ: if (rd_ready) st_q <= F_WAIT;
        F_WAIT: if (rsp_valid) begin
          buf_q[int'(idx_q)*DATA_W +: DATA_W] <= rsp_data;
          if (idx_q == IDX_W'(WORDS-1)) begin
            desc_valid <= 1'b1;
            st_q       <= F_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= F_REQ;
          end
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgw_decode.sv
module sgw_decode
  import sgw_pkg::*;
(
  input  sgw_desc_t              d,
  input  logic                   first,
  input  logic                   dir_ref,
  output logic [SGW_ADDR_W-1:0]  addr,
  output logic [SGW_BYTES_W-1:0] bytes,
  output logic                   outbound,
  output logic                   order,
  output logic [3:0]             mode,
  output logic                   last,
  output logic [SGW_ADDR_W-1:0]  next,
  output logic                   bad,
  output sgw_err_e               code
);
  logic [SGW_BYTES_W-1:0] end_a;
  logic zero_len, crosses, dir_bad;
  logic unused_fields;

  assign addr     = d.buf_addr;
  assign bytes    = {d.len_units, 3'b000};
  assign outbound = d.flags[FLG_OUT];
  assign order    = d.flags[FLG_ORDER];
  assign last     = d.flags[FLG_LAST];
  assign mode     = d.mode_byte[3:0];
  assign next     = d.next;
  assign unused_fields = ^{d.rsvd, d.pkt_len, d.mode_byte[7:4], d.flags[6], d.flags[3:0]};

  assign end_a    = {3'b000, d.buf_addr} + bytes;
  assign zero_len = (d.len_units == '0);
  assign crosses  = (end_a > SGW_BYTES_W'(35'h1_0000_0000));
  assign dir_bad  = !first && (outbound != dir_ref);
  assign bad      = zero_len || crosses || dir_bad;

  always_comb begin
    if (zero_len)     code = ERR_ZERO_LEN;
    else if (crosses) code = ERR_CROSS;
    else              code = ERR_DIR;
  end
endmodule

// File: rtl/sgw_chain_walker.sv
module sgw_chain_walker
  import sgw_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MAX_DESC = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [SGW_ADDR_W-1:0]  head_addr,
  output logic                   busy,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic [SGW_ADDR_W-1:0]  rd_addr,
  input  logic                   rsp_valid,
  input  logic [DATA_W-1:0]      rsp_data,
  output logic                   xfer_valid,
  input  logic                   xfer_ready,
  output logic [SGW_ADDR_W-1:0]  xfer_addr,
  output logic [SGW_BYTES_W-1:0] xfer_bytes,
  output logic                   xfer_outbound,
  output logic                   xfer_order,
  output logic [3:0]             xfer_mode,
  input  logic                   xfer_ack,
  output logic                   done,
  output logic                   error,
  output logic [1:0]             err_code
);
  localparam int CNT_W = $clog2(MAX_DESC + 1);

  typedef enum logic [1:0] {W_IDLE, W_FETCH, W_ISSUE, W_ACK} walk_st_e;

  walk_st_e              st_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  dir_q;
  logic                  fetch_go;
  logic [SGW_ADDR_W-1:0] fetch_base;
  logic                  desc_valid;
  sgw_desc_t             desc;
  logic                  d_last, d_bad;
  logic [SGW_ADDR_W-1:0] d_next;
  sgw_err_e              d_code;
  logic                  at_limit;

  sgw_fetch #(.DATA_W(DATA_W)) fetch_i (
    .clk, .rst_n,
    .go(fetch_go), .base(fetch_base),
    .rd_valid, .rd_ready, .rd_addr,
    .rsp_valid, .rsp_data,
    .desc_valid, .desc
  );

  sgw_decode decode_i (
    .d(desc), .first(cnt_q == '0), .dir_ref(dir_q),
    .addr(xfer_addr), .bytes(xfer_bytes), .outbound(xfer_outbound),
    .order(xfer_order), .mode(xfer_mode), .last(d_last), .next(d_next),
    .bad(d_bad), .code(d_code)
  );

  assign at_limit   = (cnt_q == CNT_W'(MAX_DESC));
  assign fetch_go   = ((st_q == W_IDLE) && start) ||
                      ((st_q == W_ACK) && xfer_ack && !d_last && !at_limit);
  assign fetch_base = (st_q == W_IDLE) ? head_addr : d_next;
  assign xfer_valid = (st_q == W_ISSUE);
  assign busy       = (st_q != W_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= W_IDLE;
      cnt_q    <= '0;
      dir_q    <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      err_code <= 2'd0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (st_q)
        W_IDLE: if (start) begin
          cnt_q <= '0;
          st_q  <= W_FETCH;
        end
        W_FETCH: if (desc_valid) begin
          if (d_bad) begin
            error    <= 1'b1;
            err_code <= d_code;
            st_q     <= W_IDLE;
          end else begin
            if (cnt_q == '0) dir_q <= xfer_outbound;
            cnt_q <= cnt_q + 1'b1;
            st_q  <= W_ISSUE;
          end
        end
        W_ISSUE: if (xfer_ready) st_q <= W_ACK;
        W_ACK: if (xfer_ack) begin
          if (d_last) begin
            done <= 1'b1;
            st_q <= W_IDLE;
          end else if (at_limit) begin
            error    <= 1'b1;
            err_code <= ERR_LONG;
            st_q     <= W_IDLE;
          end else begin
            st_q <= W_FETCH;
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgw_chain_walker_chk.sv
module sgw_chain_walker_chk #(
  parameter int MAX_DESC = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [31:0] rd_addr,
  input logic        xfer_valid,
  input logic        xfer_ready,
  input logic [31:0] xfer_addr,
  input logic [34:0] xfer_bytes,
  input logic        xfer_outbound,
  input logic [3:0]  xfer_mode,
  input logic        xfer_ack,
  input logic        done,
  input logic        error
);
  logic        pend_q;
  logic [15:0] issued_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      issued_q <= '0;
    end else begin
      if (xfer_valid && xfer_ready) pend_q <= 1'b1;
      else if (xfer_ack)            pend_q <= 1'b0;
      if (start && !busy)               issued_q <= '0;
      else if (xfer_valid && xfer_ready) issued_q <= issued_q + 1'b1;
    end
  end

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) &&
      $stable(xfer_bytes) && $stable(xfer_outbound) && $stable(xfer_mode));

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  p_quiet_until_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !xfer_valid && !rd_valid);

  p_done_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(xfer_ack) && $past(pend_q));

  p_nonzero_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> xfer_bytes != '0);

  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> ({3'b000, xfer_addr} + xfer_bytes) <= 35'h1_0000_0000);

  p_chain_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    issued_q <= 16'(MAX_DESC));

  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  p_idle_on_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> !busy);
endmodule

bind sgw_chain_walker sgw_chain_walker_chk #(.MAX_DESC(MAX_DESC)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
  .xfer_bytes(xfer_bytes), .xfer_outbound(xfer_outbound), .xfer_mode(xfer_mode),
  .xfer_ack(xfer_ack), .done(done), .error(error)
);

// File: tb/sgw_chain_walker_tb.sv
module sgw_chain_walker_tb_top;
  localparam int MAXD = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] head_addr = '0;
  logic        busy, rd_valid, rd_ready = 1'b0;
  logic [31:0] rd_addr;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        xfer_valid, xfer_ready = 1'b0;
  logic [31:0] xfer_addr;
  logic [34:0] xfer_bytes;
  logic        xfer_outbound, xfer_order;
  logic [3:0]  xfer_mode;
  logic        xfer_ack = 1'b0;
  logic        done, error;
  logic [1:0]  err_code;

  sgw_chain_walker #(.DATA_W(32), .MAX_DESC(MAXD)) dut_i (
    .clk, .rst_n, .start, .head_addr, .busy,
    .rd_valid, .rd_ready, .rd_addr, .rsp_valid, .rsp_data,
    .xfer_valid, .xfer_ready, .xfer_addr, .xfer_bytes, .xfer_outbound,
    .xfer_order, .xfer_mode, .xfer_ack, .done, .error, .err_code
  );

  always #2.5 clk = ~clk;

  logic [31:0] mem [0:255];
  int n_chk = 0, n_bad = 0;
  int cycles = 0;

  // environment state
  logic        bp = 1'b0, tgl = 1'b0, hs_pend = 1'b0;
  logic [31:0] hs_addr = '0;
  int          ack_dly = 1, ack_cnt = 0;
  int          rd_n = 0, req_n = 0, done_n = 0, err_n = 0;
  logic [1:0]  last_code = '0;
  logic [31:0] r_addr [0:15];
  logic [34:0] r_bytes [0:15];
  logic        r_out [0:15];
  logic        r_ord [0:15];
  logic [3:0]  r_mode [0:15];

  always @(posedge clk) cycles++;

  always @(negedge clk) begin
    tgl = ~tgl;
    xfer_ack = 1'b0;
    if (rsp_valid) rsp_valid = 1'b0;
    if (hs_pend) begin
      rsp_valid = 1'b1;
      rsp_data  = mem[hs_addr[9:2]];
      hs_pend   = 1'b0;
    end
    rd_ready = bp ? tgl : 1'b1;
    if (rd_valid && rd_ready) begin
      hs_pend = 1'b1;
      hs_addr = rd_addr;
      rd_n++;
    end
    xfer_ready = bp ? ~tgl : 1'b1;
    if (ack_cnt > 0) begin
      ack_cnt--;
      if (ack_cnt == 0) xfer_ack = 1'b1;
    end
    if (xfer_valid && xfer_ready) begin
      if (req_n < 16) begin
        r_addr[req_n]  = xfer_addr;
        r_bytes[req_n] = xfer_bytes;
        r_out[req_n]   = xfer_outbound;
        r_ord[req_n]   = xfer_order;
        r_mode[req_n]  = xfer_mode;
      end
      req_n++;
      ack_cnt = ack_dly;
    end
    if (done) done_n++;
    if (error) begin
      err_n++;
      last_code = err_code;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // descriptor writer: bytes 10/11 and unused flag/mode bits hold junk that must be ignored
  task automatic put_desc(input int at, input logic [31:0] a, input logic [31:0] len,
                          input bit out, input bit ord, input bit last,
                          input logic [3:0] mode, input logic [31:0] nxt);
    mem[at/4]     = a;
    mem[at/4 + 1] = len;
    mem[at/4 + 2] = {8'hA5, 8'h3C, 4'hB, mode, last, 1'b1, out, ord, 4'b1010};
    mem[at/4 + 3] = nxt;
  endtask

  task automatic run_chain(input logic [31:0] head, input bit restart_busy);
    rd_n = 0; req_n = 0; done_n = 0; err_n = 0;
    @(negedge clk);
    head_addr = head;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart_busy) begin
      repeat (3) @(negedge clk);
      head_addr = 32'h0000_0200;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 3000; i++) begin
      if (done_n + err_n > 0) break;
      @(negedge clk);
    end
    check(done_n + err_n > 0, "R10 walk ended", done_n + err_n, 1);
    repeat (4) @(negedge clk);
    check(!busy, "R10 busy low after outcome", busy, 0);
  endtask

  task automatic chk_req(input int i, input logic [31:0] a, input logic [34:0] b,
                         input bit out, input bit ord, input logic [3:0] mode);
    check(r_addr[i] == a, "R2 addr", r_addr[i], a);
    check(r_bytes[i] == b, "R2 bytes", r_bytes[i], b);
    check(r_out[i] == out, "R1 outbound flag", r_out[i], out);
    check(r_ord[i] == ord, "R1 order flag", r_ord[i], ord);
    check(r_mode[i] == mode, "R1 mode nibble", r_mode[i], mode);
  endtask

  task automatic t_reset;
    check(!busy && !rd_valid && !xfer_valid && !done && !error, "R10 reset idle",
          {busy, rd_valid, xfer_valid, done, error}, 0);
  endtask

  task automatic t_basic_chain;  // R1 R2 R4 R5
    put_desc(32'h40, 32'h1000_0000, 32'h10,  1'b0, 1'b1, 1'b0, 4'h3, 32'h80);
    put_desc(32'h80, 32'h2345_6780, 32'h1,   1'b0, 1'b0, 1'b0, 4'h5, 32'hC0);
    put_desc(32'hC0, 32'h0000_8000, 32'h200, 1'b0, 1'b0, 1'b1, 4'hA, 32'h0);
    bp = 1'b0; ack_dly = 1;
    run_chain(32'h40, 1'b0);
    check(req_n == 3, "R4 request count", req_n, 3);
    chk_req(0, 32'h1000_0000, 35'h80,   1'b0, 1'b1, 4'h3);
    chk_req(1, 32'h2345_6780, 35'h8,    1'b0, 1'b0, 4'h5);
    chk_req(2, 32'h0000_8000, 35'h1000, 1'b0, 1'b0, 4'hA);
    check(done_n == 1 && err_n == 0, "R5 done once", {done_n, err_n}, 1);
    check(rd_n == 12, "R1 word reads", rd_n, 12);
  endtask

  task automatic t_backpressure;  // R3 R10 R11
    put_desc(32'h100, 32'h0000_1000, 32'h3, 1'b1, 1'b0, 1'b0, 4'h7, 32'h140);
    put_desc(32'h140, 32'h0000_2000, 32'h4, 1'b1, 1'b1, 1'b1, 4'h1, 32'h40);
    put_desc(32'h200, 32'hDEAD_0000, 32'h9, 1'b1, 1'b0, 1'b1, 4'h2, 32'h0);
    bp = 1'b1; ack_dly = 5;
    run_chain(32'h100, 1'b1);
    check(req_n == 2, "R10 start ignored while busy", req_n, 2);
    chk_req(0, 32'h0000_1000, 35'h18, 1'b1, 1'b0, 4'h7);
    chk_req(1, 32'h0000_2000, 35'h20, 1'b1, 1'b1, 4'h1);
    check(done_n == 1, "R11 done under back-pressure", done_n, 1);
    check(rd_n == 8, "R11 reads under back-pressure", rd_n, 8);
    bp = 1'b0; ack_dly = 1;
  endtask

  task automatic t_single_last;  // R5
    put_desc(32'h180, 32'h0000_4000, 32'h2, 1'b0, 1'b0, 1'b1, 4'h0, 32'h40);
    run_chain(32'h180, 1'b0);
    check(rd_n == 4, "R5 next pointer ignored", rd_n, 4);
    check(req_n == 1 && done_n == 1, "R5 single done", {req_n, done_n}, 2);
  endtask

  task automatic t_zero_len;  // R6
    put_desc(32'h240, 32'h0000_1000, 32'h1, 1'b0, 1'b0, 1'b0, 4'h0, 32'h280);
    put_desc(32'h280, 32'h0000_3000, 32'h0, 1'b0, 1'b0, 1'b1, 4'h0, 32'h0);
    run_chain(32'h240, 1'b0);
    check(req_n == 1, "R6 no request for zero length", req_n, 1);
    check(err_n == 1 && done_n == 0, "R6 error pulse", {err_n, done_n}, 1);
    check(last_code == 2'd0, "R6 code", last_code, 0);
  endtask

  task automatic t_boundary;  // R7
    put_desc(32'h2C0, 32'hFFFF_FFF8, 32'h1, 1'b0, 1'b0, 1'b0, 4'h0, 32'h300);
    put_desc(32'h300, 32'hFFFF_FFF8, 32'h2, 1'b0, 1'b0, 1'b1, 4'h0, 32'h0);
    run_chain(32'h2C0, 1'b0);
    check(req_n == 1, "R7 end at 4GiB accepted", req_n, 1);
    check(r_bytes[0] == 35'h8, "R7 bytes at edge", r_bytes[0], 8);
    check(err_n == 1 && last_code == 2'd1, "R7 cross code", last_code, 1);
  endtask

  task automatic t_dir_mismatch;  // R8
    put_desc(32'h340, 32'h0000_1000, 32'h1, 1'b1, 1'b0, 1'b0, 4'h0, 32'h380);
    put_desc(32'h380, 32'h0000_2000, 32'h1, 1'b0, 1'b0, 1'b1, 4'h0, 32'h0);
    run_chain(32'h340, 1'b0);
    check(req_n == 1, "R8 request count", req_n, 1);
    check(err_n == 1 && last_code == 2'd2, "R8 dir code", last_code, 2);
  endtask

  task automatic t_loop;  // R9
    put_desc(32'h3C0, 32'h0000_5000, 32'h1, 1'b0, 1'b0, 1'b0, 4'h0, 32'h3C0);
    run_chain(32'h3C0, 1'b0);
    check(req_n == MAXD, "R9 requests up to limit", req_n, MAXD);
    check(rd_n == 4 * MAXD, "R9 no read past limit", rd_n, 4 * MAXD);
    check(err_n == 1 && last_code == 2'd3, "R9 long code", last_code, 3);
  endtask

  task automatic t_priority;  // R12
    put_desc(32'h40, 32'h0000_1000, 32'h1, 1'b1, 1'b0, 1'b0, 4'h0, 32'h80);
    put_desc(32'h80, 32'h0000_2000, 32'h0, 1'b0, 1'b0, 1'b1, 4'h0, 32'h0);
    run_chain(32'h40, 1'b0);
    check(last_code == 2'd0, "R12 zero beats dir", last_code, 0);
    put_desc(32'h80, 32'hFFFF_FFF0, 32'h4, 1'b0, 1'b0, 1'b1, 4'h0, 32'h0);
    run_chain(32'h40, 1'b0);
    check(last_code == 2'd1, "R12 cross beats dir", last_code, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_basic_chain();
    t_backpressure();
    t_single_last();
    t_zero_len();
    t_boundary();
    t_dir_mismatch();
    t_loop();
    t_priority();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule